// File: doc/BRIEF.md
# Table-Based Sine Oscillator

This block produces a sampled sine wave whose frequency is set by a small unsigned step word. A phase register advances by a fixed multiple of the step once per output period. Its value addresses a full-cycle sine table held in a synchronous read-only memory. The table is filled at elaboration by a function, so no data file is read.

An internal divider paces the block. Each output period is a fixed number of clocks. A one-clock strobe marks the clock on which the registered table output carries the new sample. Downstream logic needs only to capture the sample when the strobe is high. The sample holds its value between strobes.

Top module: `nco_table_osc`

## Requirements
- R1: While reset is high, and on the first clock after it, `valid_o` is low. Reset clears the phase and the divider, and `sample_o` reads 0.
- R2: `valid_o` is never high on two consecutive clocks.
- R3: After reset is released, the first `valid_o` pulse comes on the 196th rising edge. Each later pulse comes exactly 195 clocks after the one before it.
- R4: At each update the 10-bit phase grows by `step_i` times 8, modulo 1024. The n-th sample after reset is entry (n * 8 * step) mod 1024 of the table, for a constant step.
- R5: Table entry k, for k in 0..1023, equals floor(131071 * sin(2*pi*k/1024) + 0.5). It is delivered as an 18-bit two's-complement value on `sample_o`.
- R6: `sample_o` changes only on a clock on which `valid_o` is high.
- R7: `step_i` is sampled only on the clock edge one cycle before the edge that raises `valid_o`. A change of `step_i` that is undone before that edge has no effect on any sample.
- R8: With `step_i` equal to 0, every sample repeats the previous value, and `valid_o` keeps pulsing every 195 clocks.
- R9: The phase wraps past 1023 with no gap or skipped entry. For example, with step 63 the phase advances by 504 per sample and continues through 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 6 | Unsigned frequency step |
| sample_o | output | 18 | Signed sine sample, registered table output |
| valid_o | output | 1 | One-clock strobe marking a new sample |

## Verification
The assertions check on every cycle:
- the pulse width of the strobe, and its fixed spacing;
- that the strobe follows the divider update by exactly two clocks;
- that the phase moves only on an update, and then by eight times the step seen on that edge;
- that the sample holds steady between strobes.

Only the bench scenarios can show that sample values match the sine formula at the expected table positions. The same holds for wrap-around at large steps, for the silent effect of a step change that is reverted before the update, and for a constant output at step zero.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam real TWO_PI = 6.283185307179586;

  // Rounded full-scale sine entry for index k of a table with depth entries.
  function automatic int sine_entry(input int k, input int depth, input int width);
    real amp;
    real x;
    amp = (2.0 ** (width - 1)) - 1.0;
    x   = amp * $sin(TWO_PI * k / depth);
    return $rtoi($floor(x + 0.5));
  endfunction
endpackage

// File: rtl/nco_pacer.sv
module nco_pacer #(
  parameter int DIV = 195
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == CNT_W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int STEP_W  = 6,
  parameter int PHASE_W = 10,
  parameter int SHIFT   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic [STEP_W-1:0]  step,
  output logic [PHASE_W-1:0] phase
);
  function automatic logic [PHASE_W-1:0] advance(input logic [PHASE_W-1:0] p,
                                                 input logic [STEP_W-1:0] s);
    return p + (PHASE_W'(s) << SHIFT);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)      phase <= '0;
    else if (adv) phase <= advance(phase, step);
  end
endmodule

// File: rtl/nco_sine_rom.sv
module nco_sine_rom #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [DATA_W-1:0] data
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic signed [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = DATA_W'(nco_pkg::sine_entry(i, DEPTH, DATA_W));
  end

  always_ff @(posedge clk) begin
    if (rst) data <= '0;
    else     data <= mem[addr];
  end
endmodule

// File: rtl/nco_table_osc.sv
module nco_table_osc #(
  parameter int STEP_W  = 6,
  parameter int PHASE_W = 10,
  parameter int DATA_W  = 18,
  parameter int SHIFT   = 3,
  parameter int DIV     = 195
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [STEP_W-1:0]        step_i,
  output logic signed [DATA_W-1:0] sample_o,
  output logic                     valid_o
);
  logic               upd_tick;
  logic [PHASE_W-1:0] phase_q;
  logic               rd_pend;

  nco_pacer #(.DIV(DIV)) u_pacer (
    .clk  (clk),
    .rst  (rst),
    .tick (upd_tick)
  );

  nco_phase_acc #(.STEP_W(STEP_W), .PHASE_W(PHASE_W), .SHIFT(SHIFT)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .adv   (upd_tick),
    .step  (step_i),
    .phase (phase_q)
  );

  nco_sine_rom #(.ADDR_W(PHASE_W), .DATA_W(DATA_W)) u_rom (
    .clk  (clk),
    .rst  (rst),
    .addr (phase_q),
    .data (sample_o)
  );

  // Strobe delayed to match the phase register plus the table read register.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      rd_pend <= upd_tick;
      valid_o <= rd_pend;
    end
  end
endmodule

// File: rtl/nco_table_osc_chk.sv
module nco_table_osc_chk #(
  parameter int STEP_W  = 6,
  parameter int PHASE_W = 10,
  parameter int DATA_W  = 18,
  parameter int SHIFT   = 3,
  parameter int DIV     = 195
) (
  input logic                     clk,
  input logic                     rst,
  input logic [STEP_W-1:0]        step_i,
  input logic                     upd_tick,
  input logic [PHASE_W-1:0]       phase_q,
  input logic signed [DATA_W-1:0] sample_o,
  input logic                     valid_o
);
  localparam int GAP_W = $clog2(DIV + 1) + 1;

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (valid_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != {GAP_W{1'b1}}) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!valid_o && phase_q == '0));

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R3
  pulse_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && seen_q) |-> (gap_q == GAP_W'(DIV - 1)));

  // R3
  strobe_align_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(upd_tick, 2));

  // R4
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    upd_tick |=> (phase_q == $past(phase_q) + (PHASE_W'($past(step_i)) << SHIFT)));

  // R7
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_tick |=> $stable(phase_q));

  // R6
  sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(sample_o));
endmodule

bind nco_table_osc nco_table_osc_chk #(
  .STEP_W(STEP_W), .PHASE_W(PHASE_W), .DATA_W(DATA_W), .SHIFT(SHIFT), .DIV(DIV)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .step_i   (step_i),
  .upd_tick (upd_tick),
  .phase_q  (phase_q),
  .sample_o (sample_o),
  .valid_o  (valid_o)
);

// File: tb/test_nco_table_osc.sv
module test_nco_table_osc;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 195;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [5:0]         step_i = '0;
  logic signed [17:0] sample_o;
  logic               valid_o;

  int tests_run = 0;
  int tests_failed = 0;
  int exp_phase = 0;
  bit done = 1'b0;

  nco_table_osc i_nco_table_osc (
    .clk      (clk),
    .rst      (rst),
    .step_i   (step_i),
    .sample_o (sample_o),
    .valid_o  (valid_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // R5: expected table entry from the stated formula
  function automatic int ref_sine(input int k);
    real ang;
    ang = 2.0 * 3.141592653589793 * real'(k) / 1024.0;
    return $rtoi($floor(131071.0 * $sin(ang) + 0.5));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Wait for the next strobe; checks pulse width, hold, spacing and value.
  task automatic await_sample(input int use_step, input int exp_gap,
                              input int glitch, input string req);
    int  gap = 0;
    bit  held = 1'b1;
    bit  narrow = 1'b1;
    logic signed [17:0] prev = sample_o;
    do begin
      @(negedge clk);
      gap++;
      if (glitch >= 0 && gap == 50)  step_i = 6'(glitch);
      if (glitch >= 0 && gap == 120) step_i = 6'(use_step);
      if (gap == 1 && valid_o) narrow = 1'b0;
      if (!valid_o && sample_o !== prev) held = 1'b0;
    end while (!valid_o && gap < 1000);
    exp_phase = (exp_phase + use_step * 8) % 1024;
    check(narrow, "R2 valid one clock", 1, 0);
    check(held, "R6 sample held between strobes", 0, 1);
    check(gap == exp_gap, {req, " R3 strobe spacing"}, gap, exp_gap);
    check(int'(sample_o) == ref_sine(exp_phase), {req, " R4 R5 sample value"},
          int'(sample_o), ref_sine(exp_phase));
  endtask

  task automatic t_reset(input int s);
    step_i = 6'(s);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R1 valid low in reset", int'(valid_o), 0);
    check(sample_o == 0, "R1 sample zero in reset", int'(sample_o), 0);
    rst = 1'b0;
    exp_phase = 0;
    @(negedge clk);
    check(valid_o == 1'b0, "R1 valid low after reset", int'(valid_o), 0);
    check(sample_o == 0, "R1 sample zero after reset", int'(sample_o), 0);
    await_sample(s, PERIOD + 1 - 1, -1, "R3 first strobe");
  endtask

  task automatic t_sweep(input int s, input int n, input string req);
    step_i = 6'(s);
    for (int i = 0; i < n; i++) await_sample(s, PERIOD, -1, req);
  endtask

  task automatic t_zero();
    logic signed [17:0] hold;
    step_i = 6'd0;
    await_sample(0, PERIOD, -1, "R8");
    hold = sample_o;
    for (int i = 0; i < 3; i++) begin
      await_sample(0, PERIOD, -1, "R8");
      check(sample_o == hold, "R8 constant output at step 0", int'(sample_o), int'(hold));
    end
  endtask

  task automatic t_glitch();
    step_i = 6'd5;
    await_sample(5, PERIOD, 40, "R7 reverted step change");
    await_sample(5, PERIOD, 63, "R7 reverted step change");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // First strobe after release: it arrives on the 196th edge, and the first
    // check after release consumes one negedge, so 195 more are expected.
    t_reset(3);
    t_sweep(3, 4, "R4 step 3");
    t_sweep(1, 4, "R4 step 1");
    t_sweep(63, 6, "R9 wrap step 63");
    t_sweep(32, 3, "R4 step 32");
    t_zero();
    t_glitch();
    t_reset(7);
    t_sweep(7, 3, "R4 after second reset");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule